// File: doc/BRIEF.md
# Stack and Interrupt Sequencer

This block carries out the stack-based control-flow operations of an 8-bit processor. It handles hardware interrupts (maskable and non-maskable), software break, subroutine call and return, return from interrupt, and status push and pull. It holds the 8-bit stack pointer. It drives a byte-wide memory port and makes at most one access on each clock. The program counter and the status byte come in with each command. The updated values go out on `pc_out` and `psr_out` once the sequence is complete.

A command is a one-cycle `cmd_valid` strobe with an operation code on `cmd_op`. The command is taken only while the block is idle. `busy` stays high while the sequence runs, and a one-cycle `done` pulse marks the cycle in which the results are valid. After reset the block fetches the start address from the reset vector by itself.

The stack sits in page 0x01. A push stores and then decrements the pointer. A pull increments the pointer and then loads. The memory read port is combinational: `mem_rdata` must reflect `mem_addr` within the same cycle.

Top module: `stkseq_top`

## Requirements
- R1: While `rst` is high and after it falls, `sp_out` is 0xFF, `psr_out` is 0x24 and `busy` is high. In the first cycle after release the block reads 0xFFFC (PC low byte), and in the next cycle it reads 0xFFFD (PC high byte). `done` is high in the cycle after that.
- R2: A push writes address {0x01, SP} and then decrements SP. A pull first increments SP and then reads {0x01, SP}. SP wraps modulo 256.
- R3: A 16-bit push writes the high byte and then the low byte. A 16-bit pull reads the low byte and then the high byte.
- R4: IRQ (op 1) and NMI (op 2) each do five accesses:
  - push `pc_in`;
  - push `psr_in` with bit 4 cleared;
  - read PC from the vector, low byte first.
  The vector is at 0xFFFE for IRQ and 0xFFFA for NMI. `psr_out` then has bit 2 set.
- R5: Break (op 3) pushes `pc_in`+1, then pushes `psr_in` with bit 4 set. It sets bit 2 of `psr_out` and loads PC from 0xFFFE/0xFFFF.
- R6: Call (op 4) pushes `pc_in`−1 as two bytes, and `pc_out` becomes `tgt_in`.
- R7: Return (op 5) pulls two bytes, and `pc_out` is the pulled word plus one.
- R8: Return from interrupt (op 6) pulls the status byte with bit 5 forced to 1. It then pulls PC low and high, with no increment.
- R9: Status push (op 7) writes `psr_in` with bit 4 set. Status pull (op 8) loads `psr_out` with the pulled byte OR 0x20.
- R10: `done` is a single-cycle pulse. It comes in the cycle after the last access, and `busy` is low in that cycle. A sequence of N accesses accepted at a clock edge gives `done` N cycles later.
- R11: A command is ignored while `busy` is high. Op codes 0 and 9–15 are ignored in every state: no access is made and SP does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Operation code |
| pc_in | input | 16 | Program counter at command time |
| psr_in | input | 8 | Status byte at command time |
| tgt_in | input | 16 | Call target address |
| mem_rdata | input | 8 | Read data for `mem_addr`, same cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Resulting program counter |
| psr_out | output | 8 | Resulting status byte |
| sp_out | output | 8 | Stack pointer |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |

## Verification
Each sequence is accepted at a clock edge, and its results are due exactly N cycles later, where N is its access count:
- 1 access for status push and pull;
- 2 for call and return;
- 3 for return from interrupt;
- 5 for interrupts and break;
- 2 after reset release.

The bench drives a command between edges, counts N falling edges past the accepting edge, and only then checks `done`, `busy`, `pc_out`, `psr_out`, `sp_out` and the logged writes. One cycle later it checks that `done` has dropped. For ignored commands, the bench checks at the next falling edges that `busy` stayed low, that no write appeared and that SP is unchanged.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;
    localparam int DW  = 8;
    localparam int AW  = 16;
    localparam int OPW = 4;

    localparam logic [DW-1:0] STK_PAGE = 8'h01;
    localparam logic [DW-1:0] SP_INIT  = 8'hFF;
    localparam logic [DW-1:0] PSR_INIT = 8'h24;
    localparam int BIT_IMASK = 2;
    localparam int BIT_BRK   = 4;
    localparam int BIT_RSV   = 5;

    localparam logic [AW-1:0] VEC_NMI = 16'hFFFA;
    localparam logic [AW-1:0] VEC_RST = 16'hFFFC;
    localparam logic [AW-1:0] VEC_IRQ = 16'hFFFE;

    typedef enum logic [OPW-1:0] {
        OP_NONE = 4'd0, OP_IRQ = 4'd1, OP_NMI = 4'd2, OP_BRK = 4'd3,
        OP_CALL = 4'd4, OP_RET = 4'd5, OP_RTI = 4'd6, OP_PSH = 4'd7,
        OP_PUL  = 4'd8, OP_RST = 4'd9
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PUSH_H, ST_PUSH_L, ST_PUSH_P,
        ST_PULL_P, ST_PULL_L, ST_PULL_H, ST_VEC_L, ST_VEC_H
    } step_e;

    function automatic logic is_cmd(input logic [OPW-1:0] code);
        return (code >= 4'd1) && (code <= 4'd8);
    endfunction

    function automatic step_e first_step(input op_e op);
        case (op)
            OP_IRQ, OP_NMI, OP_BRK, OP_CALL: return ST_PUSH_H;
            OP_RET:                          return ST_PULL_L;
            OP_RTI, OP_PUL:                  return ST_PULL_P;
            OP_PSH:                          return ST_PUSH_P;
            OP_RST:                          return ST_VEC_L;
            default:                         return ST_IDLE;
        endcase
    endfunction

    function automatic step_e next_step(input op_e op, input step_e s);
        case (s)
            ST_PUSH_H: return ST_PUSH_L;
            ST_PUSH_L: return (op == OP_CALL) ? ST_IDLE : ST_PUSH_P;
            ST_PUSH_P: return (op == OP_PSH)  ? ST_IDLE : ST_VEC_L;
            ST_PULL_P: return (op == OP_PUL)  ? ST_IDLE : ST_PULL_L;
            ST_PULL_L: return ST_PULL_H;
            ST_VEC_L:  return ST_VEC_H;
            default:   return ST_IDLE;
        endcase
    endfunction

    function automatic logic [AW-1:0] vector_of(input op_e op);
        case (op)
            OP_NMI:  return VEC_NMI;
            OP_RST:  return VEC_RST;
            default: return VEC_IRQ;
        endcase
    endfunction

    function automatic logic is_push(input step_e s);
        return (s == ST_PUSH_H) || (s == ST_PUSH_L) || (s == ST_PUSH_P);
    endfunction

    function automatic logic is_pull(input step_e s);
        return (s == ST_PULL_P) || (s == ST_PULL_L) || (s == ST_PULL_H);
    endfunction

    function automatic logic [DW-1:0] stacked_status(input op_e op, input logic [DW-1:0] p);
        logic [DW-1:0] r;
        r = p;
        r[BIT_BRK] = (op == OP_PSH) || (op == OP_BRK);
        return r;
    endfunction
endpackage

// File: rtl/stkseq_ctrl.sv
module stkseq_ctrl
    import stkseq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_valid,
    input  logic [OPW-1:0] cmd_op,
    output step_e          step,
    output op_e            op,
    output logic           accept,
    output logic           busy,
    output logic           done
);
    step_e step_q;
    op_e   op_q;
    logic  done_q;

    assign accept = cmd_valid && (step_q == ST_IDLE) && is_cmd(cmd_op);
    assign busy   = (step_q != ST_IDLE);
    assign step   = step_q;
    assign op     = op_q;
    assign done   = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= ST_VEC_L;
            op_q   <= OP_RST;
            done_q <= 1'b0;
        end else begin
            done_q <= (step_q != ST_IDLE) && (next_step(op_q, step_q) == ST_IDLE);
            if (step_q == ST_IDLE) begin
                if (accept) begin
                    op_q   <= op_e'(cmd_op);
                    step_q <= first_step(op_e'(cmd_op));
                end
            end else begin
                step_q <= next_step(op_q, step_q);
            end
        end
    end

    AST_OP_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(op_q)); // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R10
endmodule

// File: rtl/stkseq_sp.sv
module stkseq_sp
    import stkseq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pull,
    output logic [DW-1:0] sp,
    output logic [AW-1:0] push_addr,
    output logic [AW-1:0] pull_addr
);
    logic [DW-1:0] sp_q;
    logic [DW-1:0] sp_inc;

    assign sp_inc    = sp_q + 8'd1;
    assign sp        = sp_q;
    assign push_addr = {STK_PAGE, sp_q};
    assign pull_addr = {STK_PAGE, sp_inc};

    always_ff @(posedge clk) begin
        if (rst)       sp_q <= SP_INIT;
        else if (push) sp_q <= sp_q - 8'd1;
        else if (pull) sp_q <= sp_inc;
    end
endmodule

// File: rtl/stkseq_data.sv
module stkseq_data
    import stkseq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           accept,
    input  logic [OPW-1:0] cmd_op,
    input  logic [AW-1:0]  pc_in,
    input  logic [DW-1:0]  psr_in,
    input  logic [AW-1:0]  tgt_in,
    input  step_e          step,
    input  op_e            op,
    input  logic [DW-1:0]  mem_rdata,
    input  logic [AW-1:0]  push_addr,
    input  logic [AW-1:0]  pull_addr,
    output logic [AW-1:0]  pc_w,
    output logic [DW-1:0]  psr_w,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic           mem_we
);
    logic [AW-1:0] pc_q;
    logic [AW-1:0] tgt_q;
    logic [DW-1:0] psr_q;
    op_e           new_op;

    assign new_op = op_e'(cmd_op);
    assign pc_w   = pc_q;
    assign psr_w  = psr_q;

    always_comb begin
        mem_addr  = push_addr;
        mem_wdata = '0;
        mem_we    = 1'b0;
        case (step)
            ST_PUSH_H: begin mem_we = 1'b1; mem_wdata = pc_q[AW-1:DW]; end
            ST_PUSH_L: begin mem_we = 1'b1; mem_wdata = pc_q[DW-1:0]; end
            ST_PUSH_P: begin mem_we = 1'b1; mem_wdata = stacked_status(op, psr_q); end
            ST_PULL_P, ST_PULL_L, ST_PULL_H: mem_addr = pull_addr;
            ST_VEC_L:  mem_addr = vector_of(op);
            ST_VEC_H:  mem_addr = vector_of(op) + 16'd1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            tgt_q <= '0;
            psr_q <= PSR_INIT;
        end else if (accept) begin
            case (new_op)
                OP_BRK:  pc_q <= pc_in + 16'd1;
                OP_CALL: pc_q <= pc_in - 16'd1;
                default: pc_q <= pc_in;
            endcase
            psr_q <= psr_in;
            tgt_q <= tgt_in;
        end else begin
            case (step)
                ST_PUSH_L: if (op == OP_CALL) pc_q <= tgt_q;
                ST_PUSH_P: if (op != OP_PSH) psr_q[BIT_IMASK] <= 1'b1;
                ST_PULL_P: begin
                    psr_q          <= mem_rdata;
                    psr_q[BIT_RSV] <= 1'b1;
                end
                ST_PULL_L: pc_q[DW-1:0] <= mem_rdata;
                ST_PULL_H: pc_q <= {mem_rdata, pc_q[DW-1:0]} + ((op == OP_RET) ? 16'd1 : 16'd0);
                ST_VEC_L:  pc_q[DW-1:0] <= mem_rdata;
                ST_VEC_H:  pc_q[AW-1:DW] <= mem_rdata;
                default: ;
            endcase
        end
    end

    AST_PULL_RSV_SET: assert property (@(posedge clk) disable iff (rst)
        (step == ST_PULL_P) |=> psr_q[BIT_RSV]); // R8
endmodule

// File: rtl/stkseq_top.sv
module stkseq_top
    import stkseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [3:0]  cmd_op,
    input  logic [15:0] pc_in,
    input  logic [7:0]  psr_in,
    input  logic [15:0] tgt_in,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] pc_out,
    output logic [7:0]  psr_out,
    output logic [7:0]  sp_out,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we
);
    step_e         step;
    op_e           op;
    logic          accept;
    logic          push;
    logic          pull;
    logic [AW-1:0] push_addr;
    logic [AW-1:0] pull_addr;

    assign push = is_push(step);
    assign pull = is_pull(step);

    stkseq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .step(step), .op(op), .accept(accept), .busy(busy), .done(done)
    );

    stkseq_sp u_sp (
        .clk(clk), .rst(rst), .push(push), .pull(pull), .sp(sp_out),
        .push_addr(push_addr), .pull_addr(pull_addr)
    );

    stkseq_data u_data (
        .clk(clk), .rst(rst), .accept(accept), .cmd_op(cmd_op),
        .pc_in(pc_in), .psr_in(psr_in), .tgt_in(tgt_in), .step(step), .op(op),
        .mem_rdata(mem_rdata), .push_addr(push_addr), .pull_addr(pull_addr),
        .pc_w(pc_out), .psr_w(psr_out), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we)
    );

    AST_WRITE_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[AW-1:DW] == STK_PAGE)); // R2
    AST_PUSH_POSTDEC: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (sp_out == $past(mem_addr[DW-1:0]) - 8'd1)); // R2
    AST_PULL_PREINC: assert property (@(posedge clk) disable iff (rst)
        pull |=> (sp_out == $past(mem_addr[DW-1:0]))); // R2
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R10
    AST_INT_MASK_SET: assert property (@(posedge clk) disable iff (rst)
        (done && (op == OP_IRQ || op == OP_NMI || op == OP_BRK)) |-> psr_out[BIT_IMASK]); // R4
endmodule

// File: tb/stkseq_tb.sv
module stkseq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  psr_in = '0;
    logic [15:0] tgt_in = '0;
    logic [7:0]  mem_rdata;
    logic        busy, done, mem_we;
    logic [15:0] pc_out, mem_addr;
    logic [7:0]  psr_out, sp_out, mem_wdata;

    int checks = 0;
    int errors = 0;
    int wcnt = 0;
    logic [7:0]  stk_mem [256];
    logic [15:0] wa [64];
    logic [7:0]  wd [64];

    always #5 clk = ~clk;

    stkseq_top dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .pc_in(pc_in), .psr_in(psr_in), .tgt_in(tgt_in), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .pc_out(pc_out), .psr_out(psr_out),
        .sp_out(sp_out), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we)
    );

    always_comb begin
        case (mem_addr)
            16'hFFFA: mem_rdata = 8'h11;
            16'hFFFB: mem_rdata = 8'hEE;
            16'hFFFC: mem_rdata = 8'h00;
            16'hFFFD: mem_rdata = 8'h80;
            16'hFFFE: mem_rdata = 8'hBC;
            16'hFFFF: mem_rdata = 8'h9A;
            default:  mem_rdata = (mem_addr[15:8] == 8'h01) ? stk_mem[mem_addr[7:0]] : 8'h00;
        endcase
    end

    always @(posedge clk) begin
        if (mem_we) begin
            stk_mem[mem_addr[7:0]] <= mem_wdata;
            wa[wcnt % 64] <= mem_addr;
            wd[wcnt % 64] <= mem_wdata;
            wcnt <= wcnt + 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic [15:0] pc, input logic [7:0] p, input logic [15:0] t);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; pc_in = pc; psr_in = p; tgt_in = t;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic finish_seq(input string req, input int n);
        repeat (n) @(negedge clk);
        chk(req, "done", done, 1'b1);
        chk("R10", "busy at done", busy, 1'b0);
    endtask

    task automatic chk_write(input string req, input int idx, input logic [15:0] a, input logic [7:0] d);
        chk(req, "write addr", wa[idx % 64], a);
        chk(req, "write data", wd[idx % 64], d);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "sp in reset", sp_out, 8'hFF);
        chk("R1", "busy in reset", busy, 1'b1);
        chk("R1", "psr in reset", psr_out, 8'h24);
        chk("R1", "vector low addr", mem_addr, 16'hFFFC);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "vector high addr", mem_addr, 16'hFFFD);
        @(negedge clk);
        chk("R1", "done after vector", done, 1'b1);
        chk("R1", "pc from vector", pc_out, 16'h8000);
        chk("R1", "sp after", sp_out, 8'hFF);
        @(negedge clk);
        chk("R10", "done pulse drops", done, 1'b0);
    endtask

    task automatic t_pull_status_wrap();
        issue(4'd8, 16'h0, 8'h00, 16'h0);
        finish_seq("R9", 1);
        chk("R9", "pulled status rsv forced", psr_out, 8'hE3);
        chk("R2", "sp wraps up", sp_out, 8'h00);
    endtask

    task automatic t_push_status();
        int base = wcnt;
        issue(4'd7, 16'h0, 8'h81, 16'h0);
        finish_seq("R9", 1);
        chk("R9", "write count", wcnt - base, 1);
        chk_write("R9", base, 16'h0100, 8'h91);
        chk("R2", "sp wraps down", sp_out, 8'hFF);
    endtask

    task automatic t_call_ret();
        int base = wcnt;
        issue(4'd4, 16'h1236, 8'h00, 16'h4000);
        finish_seq("R6", 2);
        chk("R6", "pc target", pc_out, 16'h4000);
        chk_write("R3", base, 16'h01FF, 8'h12);
        chk_write("R6", base + 1, 16'h01FE, 8'h35);
        chk("R2", "sp after call", sp_out, 8'hFD);
        @(negedge clk);
        chk("R10", "done pulse drops", done, 1'b0);
        issue(4'd5, 16'h0, 8'h00, 16'h0);
        finish_seq("R7", 2);
        chk("R7", "pc returned plus one", pc_out, 16'h1236);
        chk("R7", "sp after return", sp_out, 8'hFF);
    endtask

    task automatic t_irq_rti();
        int base = wcnt;
        issue(4'd1, 16'h2345, 8'h91, 16'h0);
        finish_seq("R4", 5);
        chk("R4", "irq vector pc", pc_out, 16'h9ABC);
        chk("R4", "imask set", psr_out, 8'h95);
        chk_write("R3", base, 16'h01FF, 8'h23);
        chk_write("R3", base + 1, 16'h01FE, 8'h45);
        chk_write("R4", base + 2, 16'h01FD, 8'h81);
        chk("R4", "sp", sp_out, 8'hFC);
        issue(4'd6, 16'h0, 8'h00, 16'h0);
        finish_seq("R8", 3);
        chk("R8", "psr restored rsv forced", psr_out, 8'hA1);
        chk("R8", "pc no increment", pc_out, 16'h2345);
        chk("R8", "sp", sp_out, 8'hFF);
    endtask

    task automatic t_nmi_rti();
        int base = wcnt;
        issue(4'd2, 16'h0000, 8'h10, 16'h0);
        finish_seq("R4", 5);
        chk("R4", "nmi vector pc", pc_out, 16'hEE11);
        chk("R4", "psr", psr_out, 8'h14);
        chk_write("R4", base + 2, 16'h01FD, 8'h00);
        issue(4'd6, 16'h0, 8'h00, 16'h0);
        finish_seq("R8", 3);
        chk("R8", "psr", psr_out, 8'h20);
        chk("R8", "pc", pc_out, 16'h0000);
    endtask

    task automatic t_brk_rti();
        int base = wcnt;
        issue(4'd3, 16'h10FF, 8'h00, 16'h0);
        finish_seq("R5", 5);
        chk("R5", "vector pc", pc_out, 16'h9ABC);
        chk("R5", "imask", psr_out, 8'h04);
        chk_write("R5", base, 16'h01FF, 8'h11);
        chk_write("R5", base + 1, 16'h01FE, 8'h00);
        chk_write("R5", base + 2, 16'h01FD, 8'h10);
        issue(4'd6, 16'h0, 8'h00, 16'h0);
        finish_seq("R8", 3);
        chk("R5", "pushed pc plus one", pc_out, 16'h1100);
        chk("R8", "psr", psr_out, 8'h30);
    endtask

    task automatic t_ignore_busy();
        int base = wcnt;
        issue(4'd1, 16'h5555, 8'h00, 16'h0);
        cmd_valid = 1'b1; cmd_op = 4'd4; pc_in = 16'h7777; tgt_in = 16'h3333;
        @(negedge clk);
        cmd_valid = 1'b0;
        finish_seq("R11", 4);
        chk("R11", "pc from irq not call", pc_out, 16'h9ABC);
        chk("R11", "write count", wcnt - base, 3);
        chk("R11", "sp", sp_out, 8'hFC);
        issue(4'd6, 16'h0, 8'h00, 16'h0);
        finish_seq("R8", 3);
        chk("R11", "pc restored", pc_out, 16'h5555);
    endtask

    task automatic t_bad_ops();
        int base = wcnt;
        issue(4'd9, 16'h1111, 8'h00, 16'h0);
        chk("R11", "op 9 busy", busy, 1'b0);
        issue(4'd0, 16'h1111, 8'h00, 16'h0);
        chk("R11", "op 0 busy", busy, 1'b0);
        issue(4'd15, 16'h1111, 8'h00, 16'h0);
        chk("R11", "op 15 busy", busy, 1'b0);
        @(negedge clk);
        chk("R11", "no done", done, 1'b0);
        chk("R11", "no writes", wcnt - base, 0);
        chk("R11", "sp kept", sp_out, 8'hFF);
        chk("R11", "pc kept", pc_out, 16'h5555);
    endtask

    initial begin
        stk_mem[0] <= 8'hC3;
        t_reset();
        t_pull_status_wrap();
        t_push_status();
        t_call_ret();
        t_irq_rti();
        t_nmi_rti();
        t_brk_rti();
        t_ignore_busy();
        t_bad_ops();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule